// File: doc/BRIEF.md
# Base-Offset-Scaled-Index Address Generator

This block forms addresses for memory loads and stores, for the load-effective-address operation, and for branch targets. A data address is the sum of a base, a sign-extended 32-bit immediate and an optional index. The index is shifted left by a scale code of 0 to 4 before the add. All three terms meet in one three-input adder, and the sum wraps modulo 2^64. The base is either a pointer operand taken from the belt or one of six special base registers held inside the block.

The special registers are written in two ways. A configuration port can write any of them when a process starts. The frame register and the inbound-argument register also have dedicated update hooks, driven by call, return and stack-frame operations. Three of the registers (frame, inbound-argument and thread-local) may hold not-a-result (NaR). The other three always hold a number.

NaR spreads to the result: an address built from a NaR source is reported as NaR with a zero value. There are two branch forms. A relative branch adds the signed offset to the entry address of the current function. An indirect branch passes the belt pointer through unchanged. Results appear one cycle after the request.

Top module: `addr_gen_top`

## Requirements
- R1: For data operations, when the request is accepted, `addr_o` one cycle later is the sum modulo 2^64 of the base, the sign-extended `off_i` and (`idx_i` shifted left by `scale_i`). Scale codes 5 to 7 act as a shift of 4.
- R2: When `idx_en_i` is 0, the index term is zero and `idx_nar_i` has no effect on the result.
- R3: With `base_src_i`=0 the base is `belt_base_i`. With `base_src_i`=1 it is special register `base_sel_i`, where 0=code, 1=constant pool, 2=static data, 3=frame, 4=inbound arguments and 5=thread-local. Selector codes 6 and 7 give NaR.
- R4: The result is NaR (`nar_o`=1, `addr_o`=0) when the chosen base is NaR, or when the index is enabled and `idx_nar_i` is 1. In every other case `nar_o` is 0.
- R5: Operation code 3 (relative branch) yields `func_entry_i` plus the sign-extended `off_i`. The base, the index and their NaR flags are ignored, and the result is never NaR.
- R6: Operation code 4 (indirect branch) yields `belt_base_i` unchanged, with `nar_o` equal to `belt_nar_i`. The offset and the index are ignored.
- R7: Operation codes 0 (load), 1 (store), 2 (effective address) and 5 to 7 all use the data arithmetic. `op_o` echoes the accepted code.
- R8: A configuration write (`cfg_we_i`) stores `cfg_data_i` into register `cfg_sel_i`. `cfg_nar_i` takes effect only on registers 3, 4 and 5. Registers 0, 1 and 2 never hold NaR.
- R9: `frame_we_i` writes register 3 and `inarg_we_i` writes register 4, each with its own data and NaR flag. When a hook and a configuration write target the same register in the same cycle, the hook wins.
- R10: The read port returns the current value and NaR flag of register `rd_sel_i` with no delay. Codes 6 and 7 read as 0 with NaR set.
- R11: `vld_o` is `valid_i` delayed by one cycle. While `valid_i` is 0, `addr_o`, `nar_o` and `op_o` hold their values.
- R12: After reset, `vld_o`, `addr_o` and `nar_o` are 0. Registers 0 to 2 hold 0, and registers 3 to 5 hold NaR.
- R13: A request that uses a special register in the same cycle that register is written sees the value it held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| base_src_i | input | 1 | Base source: 0 = belt, 1 = special register |
| base_sel_i | input | 3 | Special register selector |
| belt_base_i | input | 64 | Belt base operand |
| belt_nar_i | input | 1 | Belt base is NaR |
| idx_en_i | input | 1 | Index present |
| idx_i | input | 64 | Belt index operand |
| idx_nar_i | input | 1 | Index is NaR |
| scale_i | input | 3 | Index shift code |
| off_i | input | 32 | Signed immediate offset |
| func_entry_i | input | 64 | Entry address of the current function |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 3 | Configuration write target |
| cfg_data_i | input | 64 | Configuration write data |
| cfg_nar_i | input | 1 | Configuration write marks NaR |
| frame_we_i | input | 1 | Frame register update from call, return or stack-frame operations |
| frame_data_i | input | 64 | Frame update value |
| frame_nar_i | input | 1 | Frame update is NaR |
| inarg_we_i | input | 1 | Inbound-argument register update |
| inarg_data_i | input | 64 | Inbound-argument update value |
| inarg_nar_i | input | 1 | Inbound-argument update is NaR |
| rd_sel_i | input | 3 | Read port selector |
| rd_data_o | output | 64 | Read port value |
| rd_nar_o | output | 1 | Read port NaR flag |
| vld_o | output | 1 | Result valid |
| op_o | output | 3 | Operation code of the result |
| addr_o | output | 64 | Computed address or value |
| nar_o | output | 1 | Result is NaR |

## Verification
The data path is swept over every scale code, with the index and base values chosen at both ends of the range and the offsets chosen at both signs. The index values include ones with the top bit set, so a dropped shift or a clamp missing above code 4 shows up. Offsets of 0x7fffffff and 0x80000000 tell sign extension apart from zero extension, and a base near the top of the space checks that the sum wraps. Each special register is then used as a base after a write of a distinct value, which exposes a wrong selector decode. Further cases cover NaR arriving on each path and a poisoned index that is disabled. Last, the bench checks the two branch forms with garbage on the inputs they ignore, a hook and a configuration write on the same cycle, and a write in the same cycle as a use.

// File: rtl/addr_gen_pkg.sv
`timescale 1ns/1ps
package addr_gen_pkg;

  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_LEA    = 3'd2,
    OP_BR_REL = 3'd3,
    OP_BR_IND = 3'd4
  } op_e;

  localparam int unsigned SR_CODE   = 0;
  localparam int unsigned SR_CONST  = 1;
  localparam int unsigned SR_STATIC = 2;
  localparam int unsigned SR_FRAME  = 3;
  localparam int unsigned SR_INARG  = 4;
  localparam int unsigned SR_TLS    = 5;

endpackage

// File: rtl/addr_gen_base_file.sv
`timescale 1ns/1ps
module addr_gen_base_file #(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned NUM_REG   = 6,
  parameter logic [NUM_REG-1:0] NULL_MASK = 6'b111000,
  parameter int unsigned FRAME_IDX = 3,
  parameter int unsigned INARG_IDX = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  input  logic              cfg_nar_i,
  input  logic              frame_we_i,
  input  logic [ADDR_W-1:0] frame_data_i,
  input  logic              frame_nar_i,
  input  logic              inarg_we_i,
  input  logic [ADDR_W-1:0] inarg_data_i,
  input  logic              inarg_nar_i,
  input  logic [SEL_W-1:0]  use_sel_i,
  output logic [ADDR_W-1:0] use_data_o,
  output logic              use_nar_o,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [ADDR_W-1:0] rd_data_o,
  output logic              rd_nar_o
);

  logic [ADDR_W-1:0] val_q [NUM_REG];
  logic              nar_q [NUM_REG];

  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    logic              hook_we;
    logic [ADDR_W-1:0] hook_data;
    logic              hook_nar;
    logic              cfg_hit;

    if (g == FRAME_IDX) begin : g_frame
      assign hook_we   = frame_we_i;
      assign hook_data = frame_data_i;
      assign hook_nar  = frame_nar_i;
    end else if (g == INARG_IDX) begin : g_inarg
      assign hook_we   = inarg_we_i;
      assign hook_data = inarg_data_i;
      assign hook_nar  = inarg_nar_i;
    end else begin : g_nohook
      assign hook_we   = 1'b0;
      assign hook_data = '0;
      assign hook_nar  = 1'b0;
    end

    assign cfg_hit = cfg_we_i && (cfg_sel_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q[g] <= '0;
        nar_q[g] <= NULL_MASK[g];
      end else if (hook_we) begin
        val_q[g] <= hook_data;
        nar_q[g] <= NULL_MASK[g] & hook_nar;
      end else if (cfg_hit) begin
        val_q[g] <= cfg_data_i;
        nar_q[g] <= NULL_MASK[g] & cfg_nar_i;
      end
    end
  end

  // out-of-range selectors read as poison
  always_comb begin
    use_data_o = '0;
    use_nar_o  = 1'b1;
    rd_data_o  = '0;
    rd_nar_o   = 1'b1;
    for (int i = 0; i < NUM_REG; i++) begin
      if (use_sel_i == SEL_W'(i)) begin
        use_data_o = val_q[i];
        use_nar_o  = nar_q[i];
      end
      if (rd_sel_i == SEL_W'(i)) begin
        rd_data_o = val_q[i];
        rd_nar_o  = nar_q[i];
      end
    end
  end

endmodule

// File: rtl/addr_gen_adder.sv
`timescale 1ns/1ps
module addr_gen_adder #(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned OFF_W     = 32,
  parameter int unsigned SCALE_W   = 3,
  parameter int unsigned MAX_SCALE = 4
) (
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic               idx_en_i,
  input  logic [ADDR_W-1:0]  idx_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [ADDR_W-1:0]  sum_o
);

  localparam int unsigned EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] shifted [MAX_SCALE+1];
  logic [ADDR_W-1:0] scaled;
  logic [ADDR_W-1:0] off_ext;

  for (genvar s = 0; s <= MAX_SCALE; s++) begin : g_shift
    assign shifted[s] = idx_i << s;
  end

  // codes above MAX_SCALE saturate
  always_comb begin
    scaled = shifted[MAX_SCALE];
    for (int i = 0; i < MAX_SCALE; i++) begin
      if (scale_i == SCALE_W'(i)) scaled = shifted[i];
    end
    if (!idx_en_i) scaled = '0;
  end

  assign off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i};
  assign sum_o   = base_i + off_ext + scaled;

endmodule

// File: rtl/addr_gen_top.sv
`timescale 1ns/1ps
module addr_gen_top
  import addr_gen_pkg::*;
#(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned OFF_W     = 32,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned SCALE_W   = 3,
  parameter int unsigned MAX_SCALE = 4,
  parameter int unsigned NUM_REG   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [2:0]         op_i,
  input  logic               base_src_i,
  input  logic [SEL_W-1:0]   base_sel_i,
  input  logic [ADDR_W-1:0]  belt_base_i,
  input  logic               belt_nar_i,
  input  logic               idx_en_i,
  input  logic [ADDR_W-1:0]  idx_i,
  input  logic               idx_nar_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [ADDR_W-1:0]  func_entry_i,
  input  logic               cfg_we_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  input  logic [ADDR_W-1:0]  cfg_data_i,
  input  logic               cfg_nar_i,
  input  logic               frame_we_i,
  input  logic [ADDR_W-1:0]  frame_data_i,
  input  logic               frame_nar_i,
  input  logic               inarg_we_i,
  input  logic [ADDR_W-1:0]  inarg_data_i,
  input  logic               inarg_nar_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic [ADDR_W-1:0]  rd_data_o,
  output logic               rd_nar_o,
  output logic               vld_o,
  output logic [2:0]         op_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               nar_o
);

  localparam logic [NUM_REG-1:0] NULL_MASK =
    NUM_REG'((1 << SR_FRAME) | (1 << SR_INARG) | (1 << SR_TLS));

  logic [ADDR_W-1:0] spec_data;
  logic              spec_nar;

  addr_gen_base_file #(
    .ADDR_W    (ADDR_W),
    .SEL_W     (SEL_W),
    .NUM_REG   (NUM_REG),
    .NULL_MASK (NULL_MASK),
    .FRAME_IDX (SR_FRAME),
    .INARG_IDX (SR_INARG)
  ) u_base_file (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_we_i     (cfg_we_i),
    .cfg_sel_i    (cfg_sel_i),
    .cfg_data_i   (cfg_data_i),
    .cfg_nar_i    (cfg_nar_i),
    .frame_we_i   (frame_we_i),
    .frame_data_i (frame_data_i),
    .frame_nar_i  (frame_nar_i),
    .inarg_we_i   (inarg_we_i),
    .inarg_data_i (inarg_data_i),
    .inarg_nar_i  (inarg_nar_i),
    .use_sel_i    (base_sel_i),
    .use_data_o   (spec_data),
    .use_nar_o    (spec_nar),
    .rd_sel_i     (rd_sel_i),
    .rd_data_o    (rd_data_o),
    .rd_nar_o     (rd_nar_o)
  );

  logic [ADDR_W-1:0] add_base;
  logic [OFF_W-1:0]  add_off;
  logic              add_idx_en;
  logic              nar_d;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    add_base   = base_src_i ? spec_data : belt_base_i;
    add_off    = off_i;
    add_idx_en = idx_en_i;
    nar_d      = (base_src_i ? spec_nar : belt_nar_i) | (idx_en_i & idx_nar_i);
    case (op_i)
      OP_BR_REL: begin
        add_base   = func_entry_i;
        add_idx_en = 1'b0;
        nar_d      = 1'b0;
      end
      OP_BR_IND: begin
        add_base   = belt_base_i;
        add_off    = '0;
        add_idx_en = 1'b0;
        nar_d      = belt_nar_i;
      end
      default: ;
    endcase
  end

  addr_gen_adder #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .SCALE_W   (SCALE_W),
    .MAX_SCALE (MAX_SCALE)
  ) u_adder (
    .base_i   (add_base),
    .off_i    (add_off),
    .idx_en_i (add_idx_en),
    .idx_i    (idx_i),
    .scale_i  (scale_i),
    .sum_o    (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      nar_o  <= 1'b0;
      op_o   <= 3'd0;
    end else if (valid_i) begin
      addr_o <= nar_d ? '0 : sum;
      nar_o  <= nar_d;
      op_o   <= op_i;
    end
  end

endmodule

// File: rtl/addr_gen_chk.sv
`timescale 1ns/1ps
module addr_gen_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned OFF_W  = 32,
  parameter int unsigned SEL_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [ADDR_W-1:0] belt_base_i,
  input logic              belt_nar_i,
  input logic [ADDR_W-1:0] func_entry_i,
  input logic [OFF_W-1:0]  off_i,
  input logic [SEL_W-1:0]  rd_sel_i,
  input logic              rd_nar_o,
  input logic              vld_o,
  input logic [2:0]        op_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              nar_o
);

  logic [ADDR_W-1:0] off_sx;
  assign off_sx = {{(ADDR_W-OFF_W){off_i[OFF_W-1]}}, off_i};

  a_r11_vld_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> vld_o);

  a_r11_vld_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !vld_o);

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(addr_o) && $stable(nar_o) && $stable(op_o)));

  a_r4_nar_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nar_o |-> (addr_o == '0));

  a_r5_br_rel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3) |=> (!nar_o && addr_o == $past(func_entry_i) + $past(off_sx)));

  a_r6_br_ind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4) |=> (nar_o == $past(belt_nar_i) &&
                                   (nar_o || addr_o == $past(belt_base_i))));

  a_r7_op_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (op_o == $past(op_i)));

  a_r8_fixed_numeric: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i < SEL_W'(3)) |-> !rd_nar_o);

endmodule

bind addr_gen_top addr_gen_chk #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W),
  .SEL_W  (SEL_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .op_i         (op_i),
  .belt_base_i  (belt_base_i),
  .belt_nar_i   (belt_nar_i),
  .func_entry_i (func_entry_i),
  .off_i        (off_i),
  .rd_sel_i     (rd_sel_i),
  .rd_nar_o     (rd_nar_o),
  .vld_o        (vld_o),
  .op_o         (op_o),
  .addr_o       (addr_o),
  .nar_o        (nar_o)
);

// File: tb/addr_gen_top_tb.sv
`timescale 1ns/1ps
module addr_gen_top_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        base_src_i = 1'b0;
  logic [2:0]  base_sel_i = '0;
  logic [63:0] belt_base_i = '0;
  logic        belt_nar_i = 1'b0;
  logic        idx_en_i = 1'b0;
  logic [63:0] idx_i = '0;
  logic        idx_nar_i = 1'b0;
  logic [2:0]  scale_i = '0;
  logic [31:0] off_i = '0;
  logic [63:0] func_entry_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [63:0] cfg_data_i = '0;
  logic        cfg_nar_i = 1'b0;
  logic        frame_we_i = 1'b0;
  logic [63:0] frame_data_i = '0;
  logic        frame_nar_i = 1'b0;
  logic        inarg_we_i = 1'b0;
  logic [63:0] inarg_data_i = '0;
  logic        inarg_nar_i = 1'b0;
  logic [2:0]  rd_sel_i = '0;
  logic [63:0] rd_data_o;
  logic        rd_nar_o;
  logic        vld_o;
  logic [2:0]  op_o;
  logic [63:0] addr_o;
  logic        nar_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk_i = ~clk_i;

  addr_gen_top dut_i (
    .clk_i, .rst_ni, .valid_i, .op_i, .base_src_i, .base_sel_i,
    .belt_base_i, .belt_nar_i, .idx_en_i, .idx_i, .idx_nar_i, .scale_i,
    .off_i, .func_entry_i, .cfg_we_i, .cfg_sel_i, .cfg_data_i, .cfg_nar_i,
    .frame_we_i, .frame_data_i, .frame_nar_i, .inarg_we_i, .inarg_data_i,
    .inarg_nar_i, .rd_sel_i, .rd_data_o, .rd_nar_o, .vld_o, .op_o,
    .addr_o, .nar_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_res(input string req, input logic [63:0] ea, input logic en);
    chk(req, {63'd0, nar_o}, {63'd0, en});
    chk(req, addr_o, ea);
  endtask

  // assumes inputs already set at a falling edge
  task automatic fire();
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic cfg_wr(input logic [2:0] sel, input logic [63:0] d, input logic n);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_data_i = d; cfg_nar_i = n;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] sel, input logic [63:0] ed, input logic en);
    rd_sel_i = sel;
    #1;
    chk(req, rd_data_o, ed);
    chk(req, {63'd0, rd_nar_o}, {63'd0, en});
  endtask

  function automatic logic [63:0] exp_data(input logic [63:0] b, input logic [31:0] o,
                                           input logic ie, input logic [63:0] ix,
                                           input logic [2:0] sc);
    int sh;
    sh = (sc > 3'd4) ? 4 : int'(sc);
    return b + {{32{o[31]}}, o} + (ie ? (ix << sh) : 64'd0);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] idx_l [5];
    logic [31:0] off_l [5];
    logic [63:0] base_l [2];
    logic [63:0] held;
    idx_l  = '{64'd0, 64'd1, 64'd3, 64'h8000_0000_0000_0001, 64'hffff_ffff_ffff_ffff};
    off_l  = '{32'd0, 32'd1, 32'h7fff_ffff, 32'h8000_0000, 32'hffff_ffff};
    base_l = '{64'h0, 64'hffff_ffff_ffff_fff0};

    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk("R12 vld", {63'd0, vld_o}, 64'd0);
    chk_res("R12 result", 64'd0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int s = 0; s < 3; s++) rd_chk("R12 numeric reg", 3'(s), 64'd0, 1'b0);
    for (int s = 3; s < 6; s++) rd_chk("R12 nar reg", 3'(s), 64'd0, 1'b1);

    // R1 sweep
    op_i = 3'd0; base_src_i = 1'b0; idx_en_i = 1'b1;
    for (int sc = 0; sc < 8; sc++)
      for (int ii = 0; ii < 5; ii++)
        for (int oi = 0; oi < 5; oi++)
          for (int bi = 0; bi < 2; bi++) begin
            scale_i = 3'(sc); idx_i = idx_l[ii]; off_i = off_l[oi]; belt_base_i = base_l[bi];
            fire();
            chk("R11 vld", {63'd0, vld_o}, 64'd1);
            chk_res("R1 data sum", exp_data(base_l[bi], off_l[oi], 1'b1, idx_l[ii], 3'(sc)), 1'b0);
          end

    // R2 index disabled, poisoned index ignored
    idx_en_i = 1'b0; idx_i = 64'hdead_beef_0000_1234; idx_nar_i = 1'b1; scale_i = 3'd3;
    belt_base_i = 64'h1000; off_i = 32'hffff_fff0;
    fire();
    chk_res("R2 no index", 64'h0ff0, 1'b0);
    idx_nar_i = 1'b0;

    // R8/R10 configure all registers, numeric
    for (int s = 0; s < 6; s++) begin
      cfg_wr(3'(s), 64'h1111_0000_0000_0000 * (s + 1), 1'b0);
      rd_chk("R10 readback", 3'(s), 64'h1111_0000_0000_0000 * (s + 1), 1'b0);
    end
    rd_chk("R10 bad sel", 3'd6, 64'd0, 1'b1);

    // R3 special bases
    base_src_i = 1'b1; idx_en_i = 1'b1; idx_i = 64'h10; scale_i = 3'd2; off_i = 32'd8;
    for (int s = 0; s < 6; s++) begin
      base_sel_i = 3'(s);
      fire();
      chk_res("R3 special base", 64'h1111_0000_0000_0000 * (s + 1) + 64'd8 + 64'h40, 1'b0);
    end
    for (int s = 6; s < 8; s++) begin
      base_sel_i = 3'(s);
      fire();
      chk_res("R3 bad selector", 64'd0, 1'b1);
    end

    // R8 nar write to fixed reg ignored, to tls honoured
    cfg_wr(3'd1, 64'h2000, 1'b1);
    rd_chk("R8 fixed reg stays numeric", 3'd1, 64'h2000, 1'b0);
    base_sel_i = 3'd1; idx_en_i = 1'b0; off_i = 32'd4;
    fire();
    chk_res("R8 fixed reg base", 64'h2004, 1'b0);
    cfg_wr(3'd5, 64'h3000, 1'b1);
    rd_chk("R8 tls nar", 3'd5, 64'h3000, 1'b1);
    base_sel_i = 3'd5;
    fire();
    chk_res("R4 nar base", 64'd0, 1'b1);

    // R4 belt and index poison
    base_src_i = 1'b0; belt_base_i = 64'h500; belt_nar_i = 1'b1;
    fire();
    chk_res("R4 belt nar", 64'd0, 1'b1);
    belt_nar_i = 1'b0; idx_en_i = 1'b1; idx_nar_i = 1'b1;
    fire();
    chk_res("R4 index nar", 64'd0, 1'b1);
    idx_nar_i = 1'b0;

    // R5 relative branch
    op_i = 3'd3; func_entry_i = 64'h4000_0000; belt_nar_i = 1'b1; idx_nar_i = 1'b1;
    idx_i = 64'hffff; base_src_i = 1'b1; base_sel_i = 3'd7;
    off_i = 32'hffff_ff00;
    fire();
    chk_res("R5 rel back", 64'h3fff_ff00, 1'b0);
    chk("R7 op echo", {61'd0, op_o}, 64'd3);
    off_i = 32'h7fff_ffff;
    fire();
    chk_res("R5 rel fwd", 64'hbfff_ffff, 1'b0);

    // R6 indirect branch
    op_i = 3'd4; base_src_i = 1'b1; belt_base_i = 64'hcafe_0000_0000_0010; belt_nar_i = 1'b0;
    off_i = 32'h1234; idx_nar_i = 1'b0;
    fire();
    chk_res("R6 indirect", 64'hcafe_0000_0000_0010, 1'b0);
    belt_nar_i = 1'b1;
    fire();
    chk_res("R6 indirect nar", 64'd0, 1'b1);
    belt_nar_i = 1'b0;

    // R7 all data codes share arithmetic
    base_src_i = 1'b0; belt_base_i = 64'h100; idx_en_i = 1'b1; idx_i = 64'h2; scale_i = 3'd1; off_i = 32'd1;
    for (int o = 0; o < 8; o++) begin
      if (o == 3 || o == 4) continue;
      op_i = 3'(o);
      fire();
      chk_res("R7 data op", 64'h105, 1'b0);
      chk("R7 op echo", {61'd0, op_o}, 64'(o));
    end

    // R9 hook wins over same-cycle configuration write
    frame_we_i = 1'b1; frame_data_i = 64'hf00; frame_nar_i = 1'b0;
    cfg_wr(3'd3, 64'hbad, 1'b0);
    frame_we_i = 1'b0;
    rd_chk("R9 frame hook priority", 3'd3, 64'hf00, 1'b0);
    inarg_we_i = 1'b1; inarg_data_i = 64'h77; inarg_nar_i = 1'b1;
    @(negedge clk_i);
    inarg_we_i = 1'b0;
    rd_chk("R9 inarg hook nar", 3'd4, 64'h77, 1'b1);

    // R13 same-cycle write and use
    op_i = 3'd0; base_src_i = 1'b1; base_sel_i = 3'd2; idx_en_i = 1'b0; off_i = 32'd0;
    cfg_we_i = 1'b1; cfg_sel_i = 3'd2; cfg_data_i = 64'h9999; cfg_nar_i = 1'b0;
    fire();
    cfg_we_i = 1'b0;
    chk_res("R13 old value used", 64'h1111_0000_0000_0000 * 3, 1'b0);
    rd_chk("R13 new value stored", 3'd2, 64'h9999, 1'b0);

    // R11 hold while idle
    held = addr_o;
    belt_base_i = 64'h1; base_src_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R11 idle vld", {63'd0, vld_o}, 64'd0);
    chk_res("R11 hold", held, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule